// File: doc/BRIEF.md
# Premultiplied Alpha Row Blender

The block composites one row of a source plane into a row of output pixels that it holds itself. Every pixel carries alpha, red, green and blue as unsigned 16-bit values. The colour channels of the source are taken to be already scaled by their own alpha, and the background is taken to be fully opaque. A row job is opened with a start pulse. The pulse carries the first destination column, the width of the destination window and the number of staged source pixels. The block then takes source pixels over a valid/ready stream, one pixel per cycle. For each pixel it reads the output pixel at the target column, blends the two, rounds to the nearest integer and writes the result back.

The number of pixels in a job is the smaller of the window width and the staged length. Columns that fall past the end of the row are consumed but not written. The job is closed with a single-cycle done pulse. A clear input resets the row to opaque black between jobs. A registered read port gives the row to the next stage of the pipeline.

Top module: `pm_row_blend`

## Requirements
- R1: A pixel on the stream and on the read port is 64 bits, packed as alpha [63:48], red [47:32], green [31:16] and blue [15:0].
- R2: Each written colour channel is floor((s*65535 + d*(65535 - a) + 32767) / 65535). Here s is the source channel, d is the stored channel at the target column and a is the source alpha. Results above 65535 saturate to 65535.
- R3: A source alpha of 65535 writes the source colour channels unchanged. Red, green and blue all use the source pixel's alpha as their weight.
- R4: Every pixel read from the row has alpha 65535.
- R5: After a start pulse, the k-th accepted pixel (k from 0) targets column dst_x_i + k. Exactly min(dst_w_i, row_len_i) pixels are accepted. s_ready_o is low when no job is open.
- R6: A pixel whose target column is at or beyond LINE_W is consumed without any write. Columns outside the job's targets keep their contents.
- R7: done_o is high for one cycle, in the cycle after the write of the last pixel. For a job of zero pixels it is high in the cycle after the start pulse.
- R8: Reset and a clear_i pulse while no job is open set every column to alpha 65535 with red, green and blue all 0.
- R9: rd_data_o shows the pixel at column rd_addr_i one cycle after the address is presented.
- R10: While s_valid_i stays high, one pixel is accepted every cycle until the job's count is reached.
- R11: A start pulse while a job is open is ignored. The open job keeps its column, its count and its completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Fill the row with opaque black (when idle) |
| start_i | input | 1 | Open a row job |
| dst_x_i | input | CW | First destination column |
| dst_w_i | input | CW | Destination window width |
| row_len_i | input | CW | Staged source pixel count |
| s_valid_i | input | 1 | Source pixel valid |
| s_ready_o | output | 1 | Source pixel accepted when valid |
| s_pix_i | input | 64 | Source pixel, premultiplied |
| done_o | output | 1 | Job complete pulse |
| rd_addr_i | input | AW | Read column |
| rd_data_o | output | 64 | Pixel at read column, one cycle later |

## Verification
A wrong job count or a wrong base column shows at the stream edge within a cycle. Ready then stays high too long or drops too early, and done_o arrives early or late. Read-back also shows the wrong columns changed. A fault in the arithmetic or in the read-modify-write lasts in the row until the next clear. It shows on the read port at any later time, so every blended column is read back and compared with values computed from the formula. Clipping errors show as writes that wrap around to low columns, which read-back of column 0 finds.

// File: rtl/pm_blend_pkg.sv
package pm_blend_pkg;
  typedef struct packed {
    logic [15:0] a;
    logic [15:0] r;
    logic [15:0] g;
    logic [15:0] b;
  } pix_t;

  localparam logic [15:0] FULL = 16'hFFFF;
endpackage

// File: rtl/pm_chan_blend.sv
module pm_chan_blend (
  input  logic [15:0] src_i,
  input  logic [15:0] dst_i,
  input  logic [15:0] alpha_i,
  output logic [15:0] out_o
);
  logic [33:0] num;
  logic [33:0] quo;

  // 34 bits: worst case sum is about 2 * 0xFFFF^2
  assign num = {18'd0, src_i} * 34'd65535
             + {18'd0, dst_i} * {18'd0, 16'hFFFF - alpha_i}
             + 34'd32767;
  assign quo = num / 34'd65535;
  assign out_o = (quo > 34'd65535) ? 16'hFFFF : quo[15:0];
endmodule

// File: rtl/pm_line_mem.sv
module pm_line_mem #(
  parameter int LINE_W = 16,
  localparam int AW = $clog2(LINE_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [47:0]   wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [47:0]   rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [47:0]   rdata_b_o
);
  // alpha is always opaque, so only colour is stored
  logic [47:0] mem [LINE_W];

  assign rdata_a_o = mem[raddr_a_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINE_W; i++) mem[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < LINE_W; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_b_o <= '0;
    else         rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/pm_row_ctrl.sv
module pm_row_ctrl #(
  parameter int CW = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_w_i,
  input  logic [CW-1:0] row_len_i,
  input  logic        valid_i,
  output logic        ready_o,
  output logic        fire_o,
  output logic        last_o,
  output logic [CW:0] col_o,
  output logic        zero_go_o
);
  logic          busy;
  logic [CW-1:0] cnt, n_q, base_q, n_new;

  assign n_new     = (dst_w_i < row_len_i) ? dst_w_i : row_len_i;
  assign ready_o   = busy;
  assign fire_o    = busy & valid_i;
  assign last_o    = (cnt == n_q - 1'b1);
  assign col_o     = {1'b0, base_q} + {1'b0, cnt};
  assign zero_go_o = start_i & ~busy & (n_new == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; cnt <= '0; n_q <= '0; base_q <= '0;
    end else if (!busy) begin
      if (start_i && n_new != '0) begin
        busy <= 1'b1; cnt <= '0; n_q <= n_new; base_q <= dst_x_i;
      end
    end else if (fire_o) begin
      cnt <= cnt + 1'b1;
      if (last_o) busy <= 1'b0;
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt < n_q));
  a_r10_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !(fire_o && last_o)) |=> busy);
  a_r11_job_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(n_q) && $stable(base_q)));
endmodule

// File: rtl/pm_row_blend.sv
module pm_row_blend
  import pm_blend_pkg::*;
#(
  parameter int LINE_W = 16,
  localparam int AW = $clog2(LINE_W),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_w_i,
  input  logic [CW-1:0] row_len_i,
  input  logic          s_valid_i,
  output logic          s_ready_o,
  input  logic [63:0]   s_pix_i,
  output logic          done_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [63:0]   rd_data_o
);
  localparam logic [CW:0] LIM = LINE_W[CW:0];

  logic        fire, last, zero_go;
  logic [CW:0] col;
  logic        st_vld, st_last;
  logic [CW:0] st_col;
  pix_t        st_pix;
  logic [47:0] dst_rgb, rd_rgb;
  logic [2:0][15:0] src_v, dst_v, res_v;
  logic        wr_en, clr_ok;

  pm_row_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dst_x_i, .dst_w_i, .row_len_i,
    .valid_i(s_valid_i), .ready_o(s_ready_o), .fire_o(fire),
    .last_o(last), .col_o(col), .zero_go_o(zero_go)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_vld <= 1'b0; st_last <= 1'b0; st_col <= '0; st_pix <= '0;
    end else begin
      st_vld <= fire;
      if (fire) begin
        st_last <= last; st_col <= col; st_pix <= s_pix_i;
      end
    end
  end

  assign src_v = {st_pix.r, st_pix.g, st_pix.b};
  assign dst_v = dst_rgb;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    pm_chan_blend u_ch (
      .src_i(src_v[c]), .dst_i(dst_v[c]), .alpha_i(st_pix.a), .out_o(res_v[c])
    );
  end

  assign wr_en  = st_vld & (st_col < LIM);
  assign clr_ok = clear_i & ~s_ready_o & ~st_vld;

  pm_line_mem #(.LINE_W(LINE_W)) u_mem (
    .clk_i, .rst_ni, .clr_i(clr_ok), .we_i(wr_en),
    .waddr_i(st_col[AW-1:0]), .wdata_i(res_v),
    .raddr_a_i(st_col[AW-1:0]), .rdata_a_o(dst_rgb),
    .raddr_b_i(rd_addr_i), .rdata_b_o(rd_rgb)
  );

  assign rd_data_o = {FULL, rd_rgb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= (st_vld & st_last) | zero_go;
  end

  a_r3_opaque_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_vld && st_pix.a == FULL) |-> (res_v == {st_pix.r, st_pix.g, st_pix.b}));
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_vld && st_col >= LIM) |-> !wr_en);
endmodule

// File: tb/tb_pm_row_blend.sv
module tb_pm_row_blend;
  localparam int LINE_W = 16;
  localparam int AW = $clog2(LINE_W);
  localparam int CW = AW + 1;

  logic clk = 0, rst_ni = 0, clear = 0, start = 0, s_valid = 0;
  logic [CW-1:0] dst_x = 0, dst_w = 0, row_len = 0;
  logic [63:0] s_pix = 0;
  logic s_ready, done;
  logic [AW-1:0] rd_addr = 0;
  logic [63:0] rd_data;

  int vecs = 0, errs = 0, cyc = 0;
  logic [63:0] model [LINE_W];
  logic [63:0] px [8];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  pm_row_blend #(.LINE_W(LINE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .start_i(start),
    .dst_x_i(dst_x), .dst_w_i(dst_w), .row_len_i(row_len),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_pix_i(s_pix),
    .done_o(done), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [15:0] ch(input logic [15:0] s, d, a);
    longint n = longint'(s) * 65535 + longint'(d) * (65535 - longint'(a)) + 32767;
    longint q = n / 65535;
    return (q > 65535) ? 16'hFFFF : q[15:0];
  endfunction

  function automatic logic [63:0] blend(input logic [63:0] s, d);
    return {16'hFFFF, ch(s[47:32], d[47:32], s[63:48]),
            ch(s[31:16], d[31:16], s[63:48]), ch(s[15:0], d[15:0], s[63:48])};
  endfunction

  task automatic chk(input logic [63:0] act, exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    @(negedge clk); rd_addr = a[AW-1:0];
    @(posedge clk); @(negedge clk); d = rd_data;
  endtask

  task automatic check_row(input string tag);
    logic [63:0] d;
    for (int i = 0; i < LINE_W; i++) begin
      rd(i, d);
      chk(d, model[i], tag);
    end
  endtask

  // runs one job, valid held; returns cycles from last accept to done
  task automatic run(input int x, w, len, cnt, output int lat);
    int n = (w < len) ? w : len;
    int t0;
    @(negedge clk);
    dst_x = x[CW-1:0]; dst_w = w[CW-1:0]; row_len = len[CW-1:0]; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < cnt; k++) begin
      s_valid = 1; s_pix = px[k];
      chk({63'd0, s_ready}, {63'd0, k < n}, "R5 ready per count");
      if (k < n && x + k < LINE_W) model[x + k] = blend(px[k], model[x + k]);
      @(negedge clk);
    end
    s_valid = 0; t0 = cyc; lat = -1;
    chk({63'd0, s_ready}, 64'd0, "R5 ready low after count");
    for (int j = 0; j < 6 && lat < 0; j++) begin
      if (done) lat = cyc - t0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({62'd0, s_ready, done}, 64'd0, "R5 R7 reset outputs");
    for (int i = 0; i < LINE_W; i++) model[i] = {16'hFFFF, 48'd0};
    check_row("R8 reset fill R4");
  endtask

  task automatic t_opaque;
    int lat;
    px[0] = {16'hFFFF, 16'h1234, 16'h5678, 16'h9ABC};
    px[1] = {16'hFFFF, 16'hFFFF, 16'h0001, 16'h8000};
    px[2] = {16'hFFFF, 16'h0F0F, 16'hF0F0, 16'h3333};
    run(2, 3, 5, 3, lat);
    chk(lat, 1, "R7 done after last write R10");
    check_row("R3 R5 opaque copy");
  endtask

  task automatic t_partial;
    int lat;
    px[0] = {16'h8000, 16'h4000, 16'h0000, 16'h8000};
    px[1] = {16'h0001, 16'h0000, 16'h0001, 16'h0000};
    run(3, 4, 2, 2, lat);
    chk(lat, 1, "R7 done partial");
    check_row("R2 R1 rounding blend");
  endtask

  task automatic t_saturate;
    int lat;
    px[0] = {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000};
    run(2, 1, 1, 1, lat);
    chk(model[2][47:32], 16'hFFFF, "R2 saturation model");
    check_row("R2 saturate");
  endtask

  task automatic t_clip;
    int lat;
    for (int k = 0; k < 4; k++) px[k] = {16'hFFFF, 16'hAAAA + 16'(k), 16'h1111, 16'h2222};
    run(LINE_W - 2, 4, 6, 4, lat);
    chk(lat, 1, "R6 done after clipped tail");
    check_row("R6 clip no wrap");
  endtask

  task automatic t_zero;
    @(negedge clk);
    dst_x = 1; dst_w = 0; row_len = 7; start = 1;
    @(negedge clk); start = 0;
    chk({62'd0, done, s_ready}, 64'd2, "R7 zero job done");
    @(negedge clk);
    chk({63'd0, done}, 64'd0, "R7 single pulse");
  endtask

  task automatic t_restart;
    @(negedge clk);
    dst_x = 0; dst_w = 2; row_len = 2; start = 1;
    @(negedge clk);
    dst_x = 8; dst_w = 5; row_len = 5; start = 1;
    s_valid = 1; s_pix = {16'hFFFF, 48'h000100020003};
    model[0] = blend(s_pix, model[0]);
    @(negedge clk); start = 0;
    s_pix = {16'hFFFF, 48'h000400050006};
    model[1] = blend(s_pix, model[1]);
    @(negedge clk); s_valid = 0;
    chk({63'd0, s_ready}, 64'd0, "R11 count kept");
    @(negedge clk);
    chk({63'd0, done}, 64'd1, "R11 done time kept");
    check_row("R11 columns kept");
  endtask

  task automatic t_clear;
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    for (int i = 0; i < LINE_W; i++) model[i] = {16'hFFFF, 48'd0};
    check_row("R8 clear R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_opaque();
    t_partial();
    t_saturate();
    t_clip();
    t_zero();
    t_restart();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    errs++; vecs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule